// File: doc/BRIEF.md
# Multiplexed Bus Master Sequencer

This block is the master end of an asynchronous, fully handshaked backplane bus. Address and data share one 32-bit set of lines. The block starts once bus ownership has already been won. A local command names a target address, a direction, two qualifier bits and a word count. The block then runs the whole bus operation: an address phase, zero or more data phases, and a release.

While the operation runs, the address strobe acts as a lock. It is raised once and held through every data phase. It falls only when the master lets go of the bus. The slave answers with two acknowledge lines. Both pass through two-flop synchronizers before the sequencer acts on them.

Each data phase is a four-phase exchange on the data strobe. Write words are pulled from the local side one at a time. Read words are handed back with a valid pulse. A programmable cycle limit guards every wait for the slave. If the limit runs out, the operation is abandoned with a timeout status and all lines are released.

Top module: `bus_master_seq`

## Requirements
- R1: While reset is held, the address strobe, data strobe, read line, qualifier lines, line enable and `done` are all low, and `cmdReady` is high.
- R2: An accepted command places its address on `adOut` with `adOe` high, and `cbOut`/`nhOut` equal to `cmdMod[1]`/`cmdMod[0]`, at least one cycle before `asOut` rises.
- R3: `asOut` stays high without a break from its rise through every data phase, and falls only in the cycle where `done` is high. `dsOut` is never high without `asOut`.
- R4: The address stays on the lines, unchanged, until the synchronized address acknowledge has been seen.
- R5: For a write, every word is on `adOut` (with `adOe` high) one cycle before `dsOut` rises. Words go out in the order the local side supplies them. A `wrTake` pulse marks each word consumed, and the next word is then presented on `wrData`.
- R6: For a read, `dsOut` and `rdOut` rise together and `adOe` is low. The value on `adIn` when the data acknowledge is seen comes out on `rdData` with a one-cycle `rdValid` pulse.
- R7: Four-phase data handshake: `dsOut` falls after the data acknowledge is seen, and does not rise again until the acknowledge has been seen low.
- R8: Exactly `cmdCount` data phases are run. A count of zero gives an address-only operation.
- R9: On release all master lines drop together and `done` pulses for one cycle. `cmdReady` returns only once the synchronized address acknowledge is low.
- R10: If the address acknowledge does not arrive, `done` comes with `timedOut` high exactly `tmoLimit`+3 cycles after the command is accepted, with every line released.
- R11: If a data acknowledge (rise or fall) does not arrive within `tmoLimit` cycles, the operation ends with `timedOut` high and every line released.
- R12: `timedOut` is cleared when a new command is accepted, so it is low after any operation that completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| tmoLimit | input | 16 | Cycles allowed for each wait on the slave |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Sequencer can take a command |
| cmdAddr | input | 32 | Target address |
| cmdRead | input | 1 | 1 = read, 0 = write |
| cmdMod | input | 2 | Qualifier bits: [1] to cbOut, [0] to nhOut |
| cmdCount | input | 8 | Number of data words |
| wrData | input | 32 | Current write word |
| wrTake | output | 1 | Current write word has been consumed |
| rdData | output | 32 | Last read word |
| rdValid | output | 1 | rdData updated this cycle |
| done | output | 1 | Operation finished (one cycle) |
| timedOut | output | 1 | Last operation was abandoned |
| adOut | output | 32 | Value driven on the shared lines |
| adOe | output | 1 | Master drives the shared lines |
| adIn | input | 32 | Value seen on the shared lines |
| asOut | output | 1 | Address strobe |
| dsOut | output | 1 | Data strobe |
| rdOut | output | 1 | Read line |
| cbOut | output | 1 | Address qualifier (control/block) |
| nhOut | output | 1 | Transfer-type qualifier |
| akIn | input | 1 | Address acknowledge from slave |
| dkIn | input | 1 | Data acknowledge from slave |

## Verification
The command is taken at the clock edge where `cmdValid` and `cmdReady` are both high. The address appears one cycle later, and `asOut` rises one cycle after that. Every acknowledge that the slave model raises at a falling edge takes two synchronizer edges plus one state edge before it has an effect. The bench therefore does not sample fixed cycles in the normal flow. It reacts to the strobes at each falling edge, as a slave would, and checks line values at the moment a strobe changes.

The cycle counts that are exact are checked exactly:
- The acknowledge-timeout `done` is due on the `tmoLimit`+3rd falling edge after acceptance.
- `rdValid` follows the edge that sees the synchronized data acknowledge by one cycle.
- `cmdReady` is low on the first falling edge after `done` and high on the second.

// File: rtl/bms_pkg.sv
package bms_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ASETUP,
    S_AWAIT,
    S_DSETUP,
    S_DWAIT,
    S_DREL,
    S_TERM
  } seq_state_e;

  typedef struct packed {
    logic loadCmd;
    logic loadWr;
    logic capRd;
    logic decCnt;
    logic clrTmr;
    logic incTmr;
    logic setTmo;
  } seq_strobe_t;

endpackage

// File: rtl/bms_sync.sv
module bms_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stg[0] <= '0;
    else       stg[0] <= asyncIn;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stg[i] <= '0;
      else       stg[i] <= stg[i-1];
    end
  end

  assign syncOut = stg[STAGES-1];

endmodule

// File: rtl/bms_datapath.sv
module bms_datapath
  import bms_pkg::*;
#(
  parameter int DW    = 32,
  parameter int CNT_W = 8,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  seq_strobe_t      strobe,
  input  logic [DW-1:0]    cmdAddr,
  input  logic             cmdRead,
  input  logic [1:0]       cmdMod,
  input  logic [CNT_W-1:0] cmdCount,
  input  logic [DW-1:0]    wrData,
  input  logic [DW-1:0]    adIn,
  input  logic [TMO_W-1:0] tmoLimit,
  output logic [DW-1:0]    adBus,
  output logic             isRead,
  output logic [1:0]       modBits,
  output logic             countZero,
  output logic             expired,
  output logic [DW-1:0]    rdData,
  output logic             rdValid,
  output logic             timedOut
);

  logic [CNT_W-1:0] countReg;
  logic [TMO_W-1:0] timer;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      adBus    <= '0;
      isRead   <= 1'b0;
      modBits  <= '0;
      countReg <= '0;
    end else if (strobe.loadCmd) begin
      adBus    <= cmdAddr;
      isRead   <= cmdRead;
      modBits  <= cmdMod;
      countReg <= cmdCount;
    end else begin
      if (strobe.loadWr) adBus    <= wrData;
      if (strobe.decCnt) countReg <= countReg - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              timer <= '0;
    else if (strobe.clrTmr) timer <= '0;
    else if (strobe.incTmr) timer <= timer + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobe.capRd;
      if (strobe.capRd) rdData <= adIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               timedOut <= 1'b0;
    else if (strobe.loadCmd) timedOut <= 1'b0;
    else if (strobe.setTmo)  timedOut <= 1'b1;
  end

  assign countZero = (countReg == '0);
  assign expired   = (timer >= tmoLimit);

  // R8
  count_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.decCnt |-> !countZero);

  // R10
  tmo_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timedOut) |-> $past(expired));

endmodule

// File: rtl/bms_ctrl.sv
module bms_ctrl
  import bms_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic        akSync,
  input  logic        dkSync,
  input  logic        isRead,
  input  logic        countZero,
  input  logic        expired,
  output logic        cmdReady,
  output seq_strobe_t strobe,
  output logic        asOut,
  output logic        dsOut,
  output logic        rdOut,
  output logic        addrPhase,
  output logic        adOe,
  output logic        wrTake,
  output logic        done
);

  seq_state_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      S_IDLE: begin
        if (cmdValid && !akSync) begin
          strobe.loadCmd = 1'b1;
          nextState      = S_ASETUP;
        end
      end
      S_ASETUP: begin
        strobe.clrTmr = 1'b1;
        nextState     = S_AWAIT;
      end
      S_AWAIT: begin
        if (akSync) begin
          if (countZero) nextState = S_TERM;
          else begin
            strobe.loadWr = !isRead;
            nextState     = S_DSETUP;
          end
        end else if (expired) begin
          strobe.setTmo = 1'b1;
          nextState     = S_TERM;
        end else strobe.incTmr = 1'b1;
      end
      S_DSETUP: begin
        strobe.clrTmr = 1'b1;
        nextState     = S_DWAIT;
      end
      S_DWAIT: begin
        if (dkSync) begin
          strobe.capRd  = isRead;
          strobe.decCnt = 1'b1;
          strobe.clrTmr = 1'b1;
          nextState     = S_DREL;
        end else if (expired) begin
          strobe.setTmo = 1'b1;
          nextState     = S_TERM;
        end else strobe.incTmr = 1'b1;
      end
      S_DREL: begin
        if (!dkSync) begin
          if (countZero) nextState = S_TERM;
          else begin
            strobe.loadWr = !isRead;
            nextState     = S_DSETUP;
          end
        end else if (expired) begin
          strobe.setTmo = 1'b1;
          nextState     = S_TERM;
        end else strobe.incTmr = 1'b1;
      end
      S_TERM:  nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  logic dataPhase;
  assign dataPhase = (state == S_DSETUP) || (state == S_DWAIT) || (state == S_DREL);
  assign addrPhase = (state == S_ASETUP) || (state == S_AWAIT);
  assign asOut     = (state == S_AWAIT) || dataPhase;
  assign dsOut     = (state == S_DWAIT);
  assign rdOut     = dsOut && isRead;
  assign adOe      = addrPhase || (dataPhase && !isRead);
  assign wrTake    = (state == S_DSETUP) && !isRead;
  assign done      = (state == S_TERM);
  assign cmdReady  = (state == S_IDLE) && !akSync;

  // R7
  ds_after_dk_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dsOut) |-> !dkSync);

  // R3
  as_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(asOut) |-> done);

  // R6
  rd_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdOut |-> !adOe);

  // R9
  term_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!asOut && !dsOut && !adOe && !addrPhase));

endmodule

// File: rtl/bus_master_seq.sv
module bus_master_seq
  import bms_pkg::*;
#(
  parameter int DW    = 32,
  parameter int CNT_W = 8,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [TMO_W-1:0] tmoLimit,
  input  logic             cmdValid,
  output logic             cmdReady,
  input  logic [DW-1:0]    cmdAddr,
  input  logic             cmdRead,
  input  logic [1:0]       cmdMod,
  input  logic [CNT_W-1:0] cmdCount,
  input  logic [DW-1:0]    wrData,
  output logic             wrTake,
  output logic [DW-1:0]    rdData,
  output logic             rdValid,
  output logic             done,
  output logic             timedOut,
  output logic [DW-1:0]    adOut,
  output logic             adOe,
  input  logic [DW-1:0]    adIn,
  output logic             asOut,
  output logic             dsOut,
  output logic             rdOut,
  output logic             cbOut,
  output logic             nhOut,
  input  logic             akIn,
  input  logic             dkIn
);

  localparam int SYNC_STAGES = 2;

  seq_strobe_t strobe;
  logic [1:0]  hsSync;
  logic        akSync, dkSync;
  logic        isRead, countZero, expired, addrPhase;
  logic [1:0]  modBits;

  bms_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn({akIn, dkIn}), .syncOut(hsSync)
  );
  assign akSync = hsSync[1];
  assign dkSync = hsSync[0];

  bms_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .akSync(akSync), .dkSync(dkSync),
    .isRead(isRead), .countZero(countZero), .expired(expired), .cmdReady(cmdReady),
    .strobe(strobe), .asOut(asOut), .dsOut(dsOut), .rdOut(rdOut),
    .addrPhase(addrPhase), .adOe(adOe), .wrTake(wrTake), .done(done)
  );

  bms_datapath #(.DW(DW), .CNT_W(CNT_W), .TMO_W(TMO_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdAddr(cmdAddr), .cmdRead(cmdRead),
    .cmdMod(cmdMod), .cmdCount(cmdCount), .wrData(wrData), .adIn(adIn),
    .tmoLimit(tmoLimit), .adBus(adOut), .isRead(isRead), .modBits(modBits),
    .countZero(countZero), .expired(expired), .rdData(rdData), .rdValid(rdValid),
    .timedOut(timedOut)
  );

  assign cbOut = addrPhase && modBits[1];
  assign nhOut = addrPhase && modBits[0];

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(asOut) && !$past(dsOut) && !$past(akSync) && asOut) |-> $stable(adOut));

  // R5
  wr_setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(dsOut) && !rdOut) |-> ($stable(adOut) && adOe));

  // R2
  addr_setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(asOut) |-> ($past(adOe) && $stable(adOut)));

endmodule

// File: tb/bus_master_seq_bench.sv
module bus_master_seq_bench;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] addr;
    logic        rd;
    logic [1:0]  mods;
    logic [7:0]  cnt;
    logic [3:0]  dly;
    logic [31:0] base;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{addr: 32'h0000_1000, rd: 1'b0, mods: 2'b10, cnt: 8'd3, dly: 4'd0, base: 32'hCAFE_0000},
    '{addr: 32'h00AB_0040, rd: 1'b1, mods: 2'b01, cnt: 8'd4, dly: 4'd1, base: 32'h0},
    '{addr: 32'h7FFF_FFFC, rd: 1'b0, mods: 2'b00, cnt: 8'd1, dly: 4'd3, base: 32'h1234_5678},
    '{addr: 32'h8000_0000, rd: 1'b1, mods: 2'b11, cnt: 8'd1, dly: 4'd0, base: 32'h0},
    '{addr: 32'h0F0F_0F0F, rd: 1'b0, mods: 2'b01, cnt: 8'd0, dly: 4'd2, base: 32'hDEAD_BEEF},
    '{addr: 32'h0000_0008, rd: 1'b1, mods: 2'b00, cnt: 8'd5, dly: 4'd2, base: 32'h0}
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] tmoLimit;
  logic        cmdValid, cmdReady, cmdRead;
  logic [31:0] cmdAddr, wrData, rdData, adOut, adIn;
  logic [1:0]  cmdMod;
  logic [7:0]  cmdCount;
  logic        wrTake, rdValid, done, timedOut, adOe;
  logic        asOut, dsOut, rdOut, cbOut, nhOut, akIn, dkIn;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_master_seq u_bus_master_seq (
    .clk(clk), .rstN(rstN), .tmoLimit(tmoLimit), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdAddr(cmdAddr), .cmdRead(cmdRead), .cmdMod(cmdMod), .cmdCount(cmdCount),
    .wrData(wrData), .wrTake(wrTake), .rdData(rdData), .rdValid(rdValid), .done(done),
    .timedOut(timedOut), .adOut(adOut), .adOe(adOe), .adIn(adIn), .asOut(asOut),
    .dsOut(dsOut), .rdOut(rdOut), .cbOut(cbOut), .nhOut(nhOut), .akIn(akIn), .dkIn(dkIn)
  );

  int compared = 0;
  int mismatched = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rdWord(input logic [31:0] a, input int i);
    return (a ^ 32'h5A5A_0000) + i * 32'h101;
  endfunction

  // slave model state
  logic [31:0] curAddr, curBase, capAddr;
  logic [1:0]  capMod;
  bit          noAck, noDk;
  int          curDly, akWait, dkWait, wrIdx, slvIdx, rdCnt;
  logic [31:0] wrLog [16];
  logic [31:0] rdLog [16];
  logic        asPrev, dsPrev, adOePrev;
  logic [31:0] adPrev;
  int          errR2, errR3, errR4, errR5, errR7;

  always @(negedge clk) begin
    if (rstN) begin
      if (dsOut && !asOut) errR3++;
      if (asOut && !asPrev && !(adOePrev && adPrev == curAddr)) errR2++;
      if (asOut && !akIn && !(adOe && adOut == curAddr)) errR4++;
      if (dsOut && !dsPrev && !rdOut && !(adOe && adOut == adPrev)) errR5++;
      if (dsOut && !dsPrev && dkIn) errR7++;
      if (asPrev && !asOut && !done) errR3++;
    end
    if (!asOut) begin
      akIn = 1'b0;
      akWait = curDly;
    end else if (!akIn && !noAck) begin
      if (akWait == 0) begin
        akIn = 1'b1;
        capAddr = adOut;
        capMod = {cbOut, nhOut};
      end else akWait--;
    end
    if (!dsOut) begin
      dkIn = 1'b0;
      dkWait = curDly;
    end else if (!dkIn && !noDk) begin
      if (dkWait == 0) begin
        if (rdOut) adIn = rdWord(capAddr, slvIdx);
        else if (slvIdx < 16) wrLog[slvIdx] = adOut;
        slvIdx++;
        dkIn = 1'b1;
      end else dkWait--;
    end
    if (wrTake) begin
      wrIdx++;
      wrData = curBase + wrIdx * 32'h11;
    end
    if (rdValid) begin
      if (rdCnt < 16) rdLog[rdCnt] = rdData;
      rdCnt++;
    end
    asPrev = asOut; dsPrev = dsOut; adOePrev = adOe; adPrev = adOut;
  end

  int          lastN;
  logic        lastTmo, rdy1, rdy2;
  logic [4:0]  doneLines;

  task automatic run_cmd(input logic [31:0] a, input logic rd, input logic [1:0] m,
                         input logic [7:0] c, input logic [31:0] b, input logic [15:0] lim,
                         input bit nak, input bit ndk, input int dly);
    int n;
    @(negedge clk); #1;
    curAddr = a; curBase = b; curDly = dly; noAck = nak; noDk = ndk;
    wrIdx = 0; slvIdx = 0; rdCnt = 0; capAddr = '0; capMod = '0;
    errR2 = 0; errR3 = 0; errR4 = 0; errR5 = 0; errR7 = 0;
    wrData = b; tmoLimit = lim;
    while (!cmdReady) begin @(negedge clk); #1; end
    cmdAddr = a; cmdRead = rd; cmdMod = m; cmdCount = c; cmdValid = 1'b1;
    @(negedge clk); #1;
    cmdValid = 1'b0;
    n = 1;
    while (!done && n < 600) begin @(negedge clk); #1; n++; end
    lastN = n; lastTmo = timedOut;
    doneLines = {asOut, dsOut, adOe, cbOut, nhOut};
    @(negedge clk); #1; rdy1 = cmdReady;
    @(negedge clk); #1; rdy2 = cmdReady;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rstN = 1'b0; tmoLimit = 16'd40; cmdValid = 1'b0; cmdRead = 1'b0; cmdAddr = '0;
    cmdMod = '0; cmdCount = '0; wrData = '0; adIn = '0; akIn = 1'b0; dkIn = 1'b0;
    curAddr = '0; curBase = '0; curDly = 0; noAck = 0; noDk = 0;
    asPrev = 0; dsPrev = 0; adOePrev = 0; adPrev = '0;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check(!asOut && !dsOut && !rdOut, "R1 strobes low", {29'b0, asOut, dsOut, rdOut}, 32'h0);
    check(!adOe && !cbOut && !nhOut, "R1 lines released", {29'b0, adOe, cbOut, nhOut}, 32'h0);
    check(!done && !timedOut, "R1 status low", {30'b0, done, timedOut}, 32'h0);
    check(cmdReady, "R1 ready", {31'b0, cmdReady}, 32'h1);
    rstN = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      vec_t t = VECS[v];
      run_cmd(t.addr, t.rd, t.mods, t.cnt, t.base, 16'd40, 1'b0, 1'b0, int'(t.dly));
      check(lastN < 600, "R9 done reached", lastN, 600);
      check(capAddr == t.addr, "R2 address seen by slave", capAddr, t.addr);
      check(capMod == t.mods, "R2 qualifiers", {30'b0, capMod}, {30'b0, t.mods});
      check(errR2 == 0, "R2 address setup", errR2, 0);
      check(errR3 == 0, "R3 strobe lock", errR3, 0);
      check(errR4 == 0, "R4 address held until ack", errR4, 0);
      check(errR5 == 0, "R5 write setup", errR5, 0);
      check(errR7 == 0, "R7 four-phase", errR7, 0);
      check(slvIdx == int'(t.cnt), "R8 data phase count", slvIdx, t.cnt);
      if (t.rd) begin
        check(rdCnt == int'(t.cnt), "R6 rdValid count", rdCnt, t.cnt);
        for (int i = 0; i < int'(t.cnt); i++)
          check(rdLog[i] == rdWord(t.addr, i), "R6 read word", rdLog[i], rdWord(t.addr, i));
      end else begin
        check(wrIdx == int'(t.cnt), "R5 wrTake count", wrIdx, t.cnt);
        for (int i = 0; i < int'(t.cnt); i++)
          check(wrLog[i] == t.base + i * 32'h11, "R5 write word", wrLog[i], t.base + i * 32'h11);
      end
      check(!lastTmo, "R12 no timeout", {31'b0, lastTmo}, 32'h0);
      check(doneLines == 5'b0, "R9 lines dropped at done", {27'b0, doneLines}, 32'h0);
      check(!rdy1 && rdy2, "R9 ready after ack low", {30'b0, rdy1, rdy2}, 32'h1);
    end

    // R10 address acknowledge never comes
    run_cmd(32'h0000_0500, 1'b0, 2'b11, 8'd2, 32'h1, 16'd5, 1'b1, 1'b0, 0);
    check(lastN == 8, "R10 timeout cycle", lastN, 8);
    check(lastTmo, "R10 timedOut set", {31'b0, lastTmo}, 32'h1);
    check(doneLines == 5'b0, "R10 lines released", {27'b0, doneLines}, 32'h0);
    check(slvIdx == 0, "R10 no data phase", slvIdx, 0);

    // R11 data acknowledge never comes
    run_cmd(32'h0000_0600, 1'b0, 2'b00, 8'd2, 32'h2, 16'd6, 1'b0, 1'b1, 0);
    check(lastTmo, "R11 timedOut set", {31'b0, lastTmo}, 32'h1);
    check(doneLines == 5'b0, "R11 lines released", {27'b0, doneLines}, 32'h0);
    check(!asOut && !dsOut && !adOe, "R11 idle after abort", {29'b0, asOut, dsOut, adOe}, 32'h0);

    // R12 a clean operation clears the flag
    run_cmd(32'h0000_0700, 1'b1, 2'b00, 8'd1, 32'h0, 16'd40, 1'b0, 1'b0, 1);
    check(!lastTmo, "R12 timedOut cleared", {31'b0, lastTmo}, 32'h0);
    check(rdCnt == 1 && rdLog[0] == rdWord(32'h0000_0700, 0), "R6 single read after abort",
          rdLog[0], rdWord(32'h0000_0700, 0));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule